// File: doc/BRIEF.md
# Status Stack Pull Sequencer

This block brings a saved processor context back from a memory stack. A start pulse hands it the current top-of-stack pointer, the number of words held on the stack, the free space left on it and the current 64-bit status. If the stack holds at least one full 28-word frame, the block walks down the frame one slot per cycle. It picks out the sixteen general registers and the two status words and passes over the other ten slots. The pointer and both counts follow each slot visited. The general registers go to the register file as a burst, and only after the whole frame has been read.

When the stack holds less than a frame, the stack is left alone. The two status words come from two fixed default addresses instead. In both cases the pulled status is merged with the current one. The interrupt-inhibit field is the OR of the old and the pulled values. The register-block field comes from the frame only when the caller sets the load-pointer flag. A one-cycle done pulse marks the point where the new status, pointer and counts are valid.

Top module: `ctx_pull_seq`

## Requirements
- R1: A start with `wcIn` of 28 or more takes the pull path (28 stack reads). A start with `wcIn` below 28 takes the default path (two reads only).
- R2: On the pull path, `rdEn` is high for 28 consecutive cycles, beginning the cycle after start. The addresses are `ptrIn`, `ptrIn`-1, ..., `ptrIn`-27, modulo 2^ADDR_W. Read data is taken one cycle after its request.
- R3: No register write happens before all 28 slots are read. After one idle cycle, 16 writes follow on consecutive cycles with `regIdx` 0 to 15. Register n gets the word read from `ptrIn`-27+n.
- R4: Each pull-path read lowers `ptrOut` and `wcOut` by one and raises `scOut` by one. At done the net changes are -28, -28 and +28, modulo the field width.
- R5: `done` is a one-cycle pulse. It comes 47 cycles after the start cycle on the pull path and 5 cycles after it on the default path. Outside an operation, `rdEn`, `regWe` and `done` stay low.
- R6: On the pull path, `newStatus[63:32]` is the word at `ptrIn`-3 and `newStatus[31:0]` is the word at `ptrIn`-2, except for the fields in R7 and R8. The slots at offsets 0, -1 and -4 to -11 affect no output.
- R7: `newStatus[7:4]` (register-block field) is the pulled value when `lpFlag` was 1 at start. Otherwise it is `curStatus[7:4]` as sampled at start.
- R8: `newStatus[58:56]` (interrupt-inhibit field) is the OR of the pulled bits and `curStatus[58:56]` as sampled at start.
- R9: On the default path, `newStatus[63:32]` is read from DEF_W1_ADDR and then `newStatus[31:0]` from DEF_W2_ADDR, with the merge rules of R7 and R8. No register is written, and `ptrOut`, `wcOut` and `scOut` equal the start inputs.
- R10: After reset, `rdEn`, `regWe` and `done` are low, and `newStatus`, `ptrOut`, `wcOut` and `scOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to pull a context |
| lpFlag | input | 1 | Take the register-block field from the stack |
| ptrIn | input | ADDR_W | Initial top-of-stack address |
| wcIn | input | WC_W | Initial word count |
| scIn | input | SC_W | Initial space count |
| curStatus | input | 2*DATA_W | Current status doubleword |
| rdEn | output | 1 | Memory read request |
| rdAddr | output | ADDR_W | Memory read address |
| rdData | input | DATA_W | Read data, valid the cycle after the request |
| regWe | output | 1 | General register write enable |
| regIdx | output | 4 | General register index |
| regData | output | DATA_W | General register write data |
| ptrOut | output | ADDR_W | Updated stack pointer |
| wcOut | output | WC_W | Updated word count |
| scOut | output | SC_W | Updated space count |
| newStatus | output | 2*DATA_W | Merged new status, valid from done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that start arrives only while the sequencer is idle. They also assume that memory returns every read exactly one cycle after its request. The stimulus waits for done plus an idle cycle before the next start, and it models the memory as a one-cycle registered read. The pointer-stepping properties also assume that an operation never begins in the cycle right after another one ends. The stimulus changes the pointer and count inputs straight after each start, which shows that only the values sampled at start matter.

// File: rtl/ctx_pull_pkg.sv
package ctx_pull_pkg;
  localparam int FRAME_SLOTS  = 28;
  localparam int GPR_COUNT    = 16;
  localparam int IDX_W        = $clog2(GPR_COUNT);
  localparam int SLOT_W       = $clog2(FRAME_SLOTS);
  localparam int W2_SLOT      = 2;
  localparam int W1_SLOT      = 3;
  localparam int RBP_LSB      = 4;
  localparam int RBP_W        = 4;
  localparam int INH_LSB      = 56;
  localparam int INH_W        = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PULL, ST_DEF, ST_DRAIN, ST_WRITE, ST_MERGE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic              load;
    logic              issue;
    logic              step;
    logic              defPath;
    logic [SLOT_W-1:0] slot;
    logic              capValid;
    logic              capDef;
    logic [SLOT_W-1:0] capSlot;
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic              finish;
  } ctrlStrb_t;
endpackage

// File: rtl/ctx_pull_ctrl.sv
module ctx_pull_ctrl
  import ctx_pull_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      frameOk,
  output ctrlStrb_t strb,
  output logic      done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(GPR_COUNT - 1);

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] capSlotQ;
  logic              capValidQ;
  logic              capDefQ;
  logic [IDX_W-1:0]  wrIdxQ;
  logic              issue;

  assign issue = (state == ST_PULL) || (state == ST_DEF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= '0;
      capSlotQ  <= '0;
      capValidQ <= 1'b0;
      capDefQ   <= 1'b0;
      wrIdxQ    <= '0;
    end else begin
      capValidQ <= issue;
      capSlotQ  <= slot;
      capDefQ   <= (state == ST_DEF);
      case (state)
        ST_IDLE: begin
          slot <= '0;
          if (start) state <= frameOk ? ST_PULL : ST_DEF;
        end
        ST_PULL: begin
          slot <= slot + 1'b1;
          if (slot == LAST_SLOT) state <= ST_DRAIN;
        end
        ST_DEF: begin
          slot <= slot + 1'b1;
          if (slot == SLOT_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          wrIdxQ <= '0;
          state  <= capDefQ ? ST_MERGE : ST_WRITE;
        end
        ST_WRITE: begin
          wrIdxQ <= wrIdxQ + 1'b1;
          if (wrIdxQ == LAST_IDX) state <= ST_MERGE;
        end
        ST_MERGE: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load     = (state == ST_IDLE) && start;
    strb.issue    = issue;
    strb.step     = (state == ST_PULL);
    strb.defPath  = (state == ST_DEF);
    strb.slot     = slot;
    strb.capValid = capValidQ;
    strb.capDef   = capDefQ;
    strb.capSlot  = capSlotQ;
    strb.wrEn     = (state == ST_WRITE);
    strb.wrIdx    = wrIdxQ;
    strb.finish   = (state == ST_MERGE);
    done          = (state == ST_DONE);
  end
endmodule

// File: rtl/ctx_pull_dpath.sv
module ctx_pull_dpath
  import ctx_pull_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WC_W   = 16,
  parameter int SC_W   = 16,
  parameter logic [ADDR_W-1:0] DEF_W1_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] DEF_W2_ADDR = 'h41
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrb_t           strb,
  input  logic                lpFlag,
  input  logic [ADDR_W-1:0]   ptrIn,
  input  logic [WC_W-1:0]     wcIn,
  input  logic [SC_W-1:0]     scIn,
  input  logic [2*DATA_W-1:0] curStatus,
  input  logic [DATA_W-1:0]   rdData,
  output logic                frameOk,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                regWe,
  output logic [IDX_W-1:0]    regIdx,
  output logic [DATA_W-1:0]   regData,
  output logic [ADDR_W-1:0]   ptrOut,
  output logic [WC_W-1:0]     wcOut,
  output logic [SC_W-1:0]     scOut,
  output logic [2*DATA_W-1:0] newStatus
);
  localparam int STAT_W = 2 * DATA_W;

  logic [ADDR_W-1:0] ptrQ;
  logic [WC_W-1:0]   wcQ;
  logic [SC_W-1:0]   scQ;
  logic              lpQ;
  logic [STAT_W-1:0] curQ;
  logic [DATA_W-1:0] w1Q, w2Q;
  logic [STAT_W-1:0] newQ;
  logic [STAT_W-1:0] merged;
  logic [DATA_W-1:0] gprStage [GPR_COUNT];

  assign frameOk = (wcIn >= WC_W'(FRAME_SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ <= '0;
      wcQ  <= '0;
      scQ  <= '0;
      lpQ  <= 1'b0;
      curQ <= '0;
    end else if (strb.load) begin
      ptrQ <= ptrIn;
      wcQ  <= wcIn;
      scQ  <= scIn;
      lpQ  <= lpFlag;
      curQ <= curStatus;
    end else if (strb.step) begin
      ptrQ <= ptrQ - 1'b1;
      wcQ  <= wcQ - 1'b1;
      scQ  <= scQ + 1'b1;
    end
  end

  always_comb begin
    if (strb.defPath) rdAddr = (strb.slot == '0) ? DEF_W1_ADDR : DEF_W2_ADDR;
    else              rdAddr = ptrQ;
  end
  assign rdEn = strb.issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      w1Q <= '0;
      w2Q <= '0;
    end else if (strb.capValid) begin
      if (strb.capDef) begin
        if (strb.capSlot == '0) w1Q <= rdData;
        else                    w2Q <= rdData;
      end else begin
        if (strb.capSlot == SLOT_W'(W1_SLOT)) w1Q <= rdData;
        if (strb.capSlot == SLOT_W'(W2_SLOT)) w2Q <= rdData;
      end
    end
  end

  for (genvar g = 0; g < GPR_COUNT; g++) begin : gen_stage
    always_ff @(posedge clk) begin
      if (rst) gprStage[g] <= '0;
      else if (strb.capValid && !strb.capDef &&
               strb.capSlot == SLOT_W'(FRAME_SLOTS - 1 - g))
        gprStage[g] <= rdData;
    end
  end

  assign regWe   = strb.wrEn;
  assign regIdx  = strb.wrIdx;
  assign regData = gprStage[strb.wrIdx];

  always_comb begin
    merged = {w1Q, w2Q};
    merged[INH_LSB +: INH_W] = w1Q[INH_LSB-DATA_W +: INH_W] | curQ[INH_LSB +: INH_W];
    if (!lpQ) merged[RBP_LSB +: RBP_W] = curQ[RBP_LSB +: RBP_W];
  end

  always_ff @(posedge clk) begin
    if (rst)              newQ <= '0;
    else if (strb.finish) newQ <= merged;
  end

  assign ptrOut    = ptrQ;
  assign wcOut     = wcQ;
  assign scOut     = scQ;
  assign newStatus = newQ;
endmodule

// File: rtl/ctx_pull_seq.sv
module ctx_pull_seq
  import ctx_pull_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WC_W   = 16,
  parameter int SC_W   = 16,
  parameter logic [ADDR_W-1:0] DEF_W1_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] DEF_W2_ADDR = 'h41
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                lpFlag,
  input  logic [ADDR_W-1:0]   ptrIn,
  input  logic [WC_W-1:0]     wcIn,
  input  logic [SC_W-1:0]     scIn,
  input  logic [2*DATA_W-1:0] curStatus,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   rdData,
  output logic                regWe,
  output logic [3:0]          regIdx,
  output logic [DATA_W-1:0]   regData,
  output logic [ADDR_W-1:0]   ptrOut,
  output logic [WC_W-1:0]     wcOut,
  output logic [SC_W-1:0]     scOut,
  output logic [2*DATA_W-1:0] newStatus,
  output logic                done
);
  ctrlStrb_t strb;
  logic      frameOk;

  ctx_pull_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .frameOk(frameOk),
    .strb(strb), .done(done)
  );

  ctx_pull_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WC_W(WC_W), .SC_W(SC_W),
    .DEF_W1_ADDR(DEF_W1_ADDR), .DEF_W2_ADDR(DEF_W2_ADDR)
  ) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .lpFlag(lpFlag),
    .ptrIn(ptrIn), .wcIn(wcIn), .scIn(scIn), .curStatus(curStatus),
    .rdData(rdData), .frameOk(frameOk), .rdEn(rdEn), .rdAddr(rdAddr),
    .regWe(regWe), .regIdx(regIdx), .regData(regData),
    .ptrOut(ptrOut), .wcOut(wcOut), .scOut(scOut), .newStatus(newStatus)
  );
endmodule

// File: rtl/ctx_pull_chk.sv
module ctx_pull_chk #(
  parameter int ADDR_W = 16,
  parameter int WC_W   = 16,
  parameter int SC_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              regWe,
  input logic [3:0]        regIdx,
  input logic [ADDR_W-1:0] ptrOut,
  input logic [WC_W-1:0]   wcOut,
  input logic [SC_W-1:0]   scOut,
  input logic              done
);
  // R3
  no_write_during_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWe && rdEn));

  // R2
  descending_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn && $past(rdEn) && (ptrOut != $past(ptrOut)) |-> rdAddr == $past(rdAddr) - 1'b1);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rdEn) && (ptrOut != $past(ptrOut)) |->
      (wcOut == $past(wcOut) - 1'b1) && (scOut == $past(scOut) + 1'b1));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  write_order_chk: assert property (@(posedge clk) disable iff (rst)
    regWe && $past(regWe) |-> regIdx == $past(regIdx) + 1'b1);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rdEn && !regWe);
endmodule

bind ctx_pull_seq ctx_pull_chk #(.ADDR_W(ADDR_W), .WC_W(WC_W), .SC_W(SC_W)) chk_i (
  .clk(clk), .rst(rst), .rdEn(rdEn), .rdAddr(rdAddr), .regWe(regWe),
  .regIdx(regIdx), .ptrOut(ptrOut), .wcOut(wcOut), .scOut(scOut), .done(done)
);

// File: tb/ctx_pull_seq_tb_top.sv
`timescale 1ns/1ps
module ctx_pull_seq_tb_top;
  localparam logic [15:0] DEF1 = 16'h0040;
  localparam logic [15:0] DEF2 = 16'h0041;

  typedef struct {
    bit          rd;
    logic [15:0] addr;
    bit          we;
    logic [3:0]  idx;
    logic [31:0] data;
    bit          dn;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        lpFlag = 1'b0;
  logic [15:0] ptrIn = '0, wcIn = '0, scIn = '0;
  logic [63:0] curStatus = '0;
  logic        rdEn, regWe, done;
  logic [15:0] rdAddr, ptrOut, wcOut, scOut;
  logic [31:0] rdData = '0, regData;
  logic [3:0]  regIdx;
  logic [63:0] newStatus;

  int          checkCnt = 0;
  int          failCnt = 0;
  bit          checking = 1'b0;
  logic [31:0] seed = 32'h1357_9BDF;
  exp_t        expQ[$];
  logic [63:0] expStat;
  logic [15:0] expPtr, expWc, expSc;
  string       statTag, cntTag;

  always #2.5 clk = ~clk;

  ctx_pull_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .lpFlag(lpFlag), .ptrIn(ptrIn),
    .wcIn(wcIn), .scIn(scIn), .curStatus(curStatus), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .regWe(regWe), .regIdx(regIdx),
    .regData(regData), .ptrOut(ptrOut), .wcOut(wcOut), .scOut(scOut),
    .newStatus(newStatus), .done(done)
  );

  function automatic logic [31:0] memWord(logic [15:0] a);
    return {a ^ seed[31:16], (a * 16'h9E37) ^ seed[15:0]};
  endfunction

  always @(posedge clk) rdData <= rdEn ? memWord(rdAddr) : 32'h0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checkCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (checking) begin
      exp_t e;
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin
        e.rd = 0; e.addr = '0; e.we = 0; e.idx = '0; e.data = '0; e.dn = 0; e.tag = "R5";
      end
      chk(e.tag, "rdEn", 64'(rdEn), 64'(e.rd));
      if (e.rd) chk(e.tag, "rdAddr", 64'(rdAddr), 64'(e.addr));
      chk(e.tag, "regWe", 64'(regWe), 64'(e.we));
      if (e.we) begin
        chk(e.tag, "regIdx", 64'(regIdx), 64'(e.idx));
        chk(e.tag, "regData", 64'(regData), 64'(e.data));
      end
      chk("R5", "done", 64'(done), 64'(e.dn));
      if (e.dn) begin
        chk(statTag, "newStatus", newStatus, expStat);
        chk(cntTag, "ptrOut", 64'(ptrOut), 64'(expPtr));
        chk(cntTag, "wcOut", 64'(wcOut), 64'(expWc));
        chk(cntTag, "scOut", 64'(scOut), 64'(expSc));
      end
    end
  end

  task automatic pushE(bit rd, logic [15:0] a, bit we, logic [3:0] i, logic [31:0] d, bit dn, string t);
    exp_t e;
    e.rd = rd; e.addr = a; e.we = we; e.idx = i; e.data = d; e.dn = dn; e.tag = t;
    expQ.push_back(e);
  endtask

  task automatic runOp(logic [15:0] p, logic [15:0] w, logic [15:0] s, logic [63:0] c, bit lp);
    bit          full;
    logic [31:0] w1, w2;
    full = (w >= 16'd28);
    @(negedge clk);
    if (full) begin
      for (int i = 0; i < 28; i++) pushE(1, p - 16'(i), 0, 0, 0, 0, "R2");
      pushE(0, 0, 0, 0, 0, 0, "R3");
      for (int k = 0; k < 16; k++) pushE(0, 0, 1, 4'(k), memWord(p - 16'd27 + 16'(k)), 0, "R3");
      pushE(0, 0, 0, 0, 0, 0, "R3");
      pushE(0, 0, 0, 0, 0, 1, "R5");
      w1 = memWord(p - 16'd3);
      w2 = memWord(p - 16'd2);
      expPtr = p - 16'd28; expWc = w - 16'd28; expSc = s + 16'd28;
      statTag = lp ? "R6/R7/R8 lp=1" : "R6/R7/R8 lp=0";
      cntTag = "R4";
    end else begin
      pushE(1, DEF1, 0, 0, 0, 0, "R9");
      pushE(1, DEF2, 0, 0, 0, 0, "R9");
      pushE(0, 0, 0, 0, 0, 0, "R9");
      pushE(0, 0, 0, 0, 0, 0, "R9");
      pushE(0, 0, 0, 0, 0, 1, "R1");
      w1 = memWord(DEF1);
      w2 = memWord(DEF2);
      expPtr = p; expWc = w; expSc = s;
      statTag = "R9";
      cntTag = "R9";
    end
    expStat = {w1, w2};
    expStat[58:56] = expStat[58:56] | c[58:56];
    if (!lp) expStat[7:4] = c[7:4];
    ptrIn = p; wcIn = w; scIn = s; curStatus = c; lpFlag = lp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ptrIn = ~p; wcIn = 16'h0; scIn = ~s; curStatus = ~c; lpFlag = ~lp;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #1000000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "rdEn", 64'(rdEn), 64'h0);
    chk("R10", "regWe", 64'(regWe), 64'h0);
    chk("R10", "done", 64'(done), 64'h0);
    chk("R10", "newStatus", newStatus, 64'h0);
    chk("R10", "ptrOut", 64'(ptrOut), 64'h0);
    chk("R10", "counts", {32'h0, wcOut, scOut}, 64'h0);
    checking = 1'b1;
    // R1 R2 R3 R4 R6 R7 R8: full frame with load-pointer flag set
    runOp(16'h1000, 16'd40, 16'd100, 64'h0500_0000_0000_00A0, 1'b1);
    // R1 boundary: exactly one frame, flag clear, space count wraps
    runOp(16'h2345, 16'd28, 16'hFFF0, 64'h0200_0000_0000_0050, 1'b0);
    // R9: one word short of a frame
    runOp(16'h3000, 16'd27, 16'd5, 64'h0100_0000_0000_00F0, 1'b1);
    // R9: empty stack, flag clear
    runOp(16'h4000, 16'd0, 16'd0, 64'h0700_0000_0000_0030, 1'b0);
    seed = 32'hCAFE_0F0F;
    // R2 address wrap below zero
    runOp(16'h0005, 16'hFFFF, 16'd7, 64'h0000_0000_0000_0000, 1'b1);
    // R7 R8 with all merge bits set in current status
    runOp(16'h8123, 16'd1000, 16'd9, 64'h0700_0000_0000_00F0, 1'b0);
    finishRun();
  end
endmodule